// File: doc/BRIEF.md
# Calibration Trigger and Pulse Sequencer

This block stages a synthetic test event for the front-end electronics. One start command launches four timed outputs: a fake trigger-candidate pulse, a fake trigger-accept pulse, a charge-pulse strobe and an injection strobe. The spacing between the candidate and the accept can be set to match the real trigger latency, and the two strobes can be placed so that the test charge arrives at a chosen moment.

The block runs on a fast clock, nominally 160 MHz (6.25 ns). A free-running divide-by-`DIV_STEP` phase counter marks coarse boundaries every 25 ns. The two trigger outputs are timed in coarse steps and last one coarse step each. The two strobes are timed in fast-clock steps and last one fast cycle each. All four delays come from a single timing word. The word is latched when a start command is accepted, and `busy_o` stays high until every output has fired.

Top module: `cal_seq_top`

## Requirements
- R1: The timing word is decoded as follows: bits 3:0 are the candidate delay C, bits 8:4 are the accept spacing A, bits 13:9 are the pulse delay P, and bits 18:14 are the inject delay J.
- R2: Number the cycles from the first cycle after reset is released (index 0). A coarse boundary is any cycle whose index is a multiple of 4. For a start accepted in cycle t0, let b0 be the first boundary after t0. `cand_o` is then high for exactly the 4 cycles that begin at cycle b0 + 4·C.
- R3: `accept_o` is high for exactly the 4 cycles that begin at b0 + 4·(C + A), so it follows the candidate by A coarse steps. When A = 0 the two pulses coincide.
- R4: `pulse_o` is high for exactly one cycle, cycle t0 + 1 + P.
- R5: `inject_o` is high for exactly one cycle, cycle t0 + 1 + J.
- R6: `busy_o` is high from cycle t0 + 1 through the last cycle in which any output is high, and it is low in the next cycle. A start that is high in that next cycle is accepted there.
- R7: A start command seen while `busy_o` is high is ignored. Neither the running sequence nor its timing is changed.
- R8: The timing word is captured in the cycle the start is accepted. Changing `timing_i` after that has no effect on the running sequence.
- R9: A synchronous reset returns the block to idle with all outputs low and clears the coarse phase. This holds even in the middle of a sequence.
- R10: The trigger outputs rise only in coarse-boundary cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock (6.25 ns step) |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start command, sampled on each clock edge |
| timing_i | input | 19 | Packed delay word (see R1) |
| busy_o | output | 1 | Sequence in progress |
| cand_o | output | 1 | Synthetic trigger-candidate pulse |
| accept_o | output | 1 | Synthetic trigger-accept pulse |
| pulse_o | output | 1 | Charge-pulse strobe |
| inject_o | output | 1 | Injection strobe |

## Verification
The assertions assume that `start_i` and `timing_i` are stable across each clock edge and free of unknowns once reset is released. They also assume that reset is held for at least one edge before the first command. The bench drives every input on the falling edge and holds reset for several cycles at the start. Starts are issued at all four coarse phases, with the delay fields at zero, at their maximum values and at mixed values. The bench also holds start high across busy periods, rewrites the timing word in the middle of a sequence, and asserts reset in the middle of a sequence.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

   // fine strobe channel indices
   localparam int unsigned FINE_PULSE  = 0;
   localparam int unsigned FINE_INJECT = 1;
   localparam int unsigned NFINE       = 2;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cal_seq_phase.sv
// Free-running coarse phase counter; flags first and last fast cycle of each step.
module cal_seq_phase #(
   parameter int unsigned DIV_STEP = 4
) (
   input  logic clk_i,
   input  logic rst_i,
   output logic first_o,
   output logic last_o
);
   localparam int unsigned PHW = (DIV_STEP > 1) ? $clog2(DIV_STEP) : 1;
   localparam logic [PHW-1:0] PH_LAST = PHW'(DIV_STEP - 1);

   logic [PHW-1:0] ph_q;

   generate
      if ((DIV_STEP & (DIV_STEP - 1)) == 0) begin : g_pow2
         always_ff @(posedge clk_i) begin
            if (rst_i) ph_q <= '0;
            else       ph_q <= ph_q + 1'b1;
         end
      end else begin : g_mod
         always_ff @(posedge clk_i) begin
            if (rst_i)                ph_q <= '0;
            else if (ph_q == PH_LAST) ph_q <= '0;
            else                      ph_q <= ph_q + 1'b1;
         end
      end
   endgenerate

   assign first_o = (ph_q == '0);
   assign last_o  = (ph_q == PH_LAST);

   // R10: a boundary always follows the last phase
   p_phase_wrap_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      last_o |=> first_o);

endmodule

// File: rtl/cal_seq_fine.sv
// One fine-step strobe timer, counting fast cycles from the accepted start.
module cal_seq_fine #(
   parameter int unsigned DW = 5
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          load_i,
   input  logic          run_i,
   input  logic [DW-1:0] dly_i,
   output logic          strobe_o,
   output logic          fired_o
);
   localparam logic [DW:0] CNT_TOP = {1'b1, {DW{1'b0}}};

   logic [DW:0] cnt_q;
   logic [DW:0] dly_x;

   assign dly_x = {1'b0, dly_i};

   always_ff @(posedge clk_i) begin
      if (rst_i)                           cnt_q <= '0;
      else if (load_i)                     cnt_q <= '0;
      else if (run_i && cnt_q != CNT_TOP)  cnt_q <= cnt_q + 1'b1;
   end

   assign strobe_o = run_i && (cnt_q == dly_x);
   assign fired_o  = (cnt_q >= dly_x);

   // R4 / R5: strobe lasts exactly one fast cycle
   p_strobe_single_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      strobe_o |=> !strobe_o);
   // R6: once fired, a channel stays fired until the next load
   p_fired_sticky_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (run_i && fired_o && !load_i) |=> fired_o);

endmodule

// File: rtl/cal_seq_coarse.sv
// Coarse-step trigger timer: candidate at step C, accept at step C+A.
module cal_seq_coarse #(
   parameter int unsigned LW = 4,
   parameter int unsigned AW = 5
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          load_i,
   input  logic          run_i,
   input  logic          ph_first_i,
   input  logic          ph_last_i,
   input  logic [LW-1:0] cand_dly_i,
   input  logic [AW-1:0] acc_dly_i,
   output logic          cand_o,
   output logic          accept_o,
   output logic          fin_o
);
   localparam int unsigned SW = $clog2((1 << LW) + (1 << AW));

   logic [SW-1:0] step_q;
   logic [SW-1:0] cand_at;
   logic [SW-1:0] acc_at;
   logic          seen_q;
   logic          done_q;
   logic          live;

   assign cand_at = SW'(cand_dly_i);
   assign acc_at  = SW'(cand_dly_i) + SW'(acc_dly_i);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         step_q <= '0;
         seen_q <= 1'b0;
         done_q <= 1'b0;
      end else if (load_i) begin
         step_q <= '0;
         seen_q <= ph_last_i;
         done_q <= 1'b0;
      end else if (run_i && ph_last_i) begin
         if (!seen_q)                 seen_q <= 1'b1;
         else if (step_q == acc_at)   done_q <= 1'b1;
         else                         step_q <= step_q + 1'b1;
      end
   end

   assign live     = run_i && seen_q && !done_q;
   assign cand_o   = live && (step_q == cand_at);
   assign accept_o = live && (step_q == acc_at);
   assign fin_o    = done_q || (seen_q && (step_q == acc_at) && ph_last_i);

   // R10: trigger pulses begin on a coarse boundary
   p_cand_on_boundary_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(cand_o) |-> ph_first_i);
   p_acc_on_boundary_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(accept_o) |-> ph_first_i);
   // R3: accept holds through the rest of its coarse step
   p_acc_width_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (accept_o && !ph_last_i) |=> accept_o);

endmodule

// File: rtl/cal_seq_top.sv
module cal_seq_top
   import cal_seq_pkg::*;
#(
   parameter int unsigned CAND_W   = 4,
   parameter int unsigned ACC_W    = 5,
   parameter int unsigned PUL_W    = 5,
   parameter int unsigned INJ_W    = 5,
   parameter int unsigned DIV_STEP = 4,
   localparam int unsigned WORD_W  = CAND_W + ACC_W + PUL_W + INJ_W
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              start_i,
   input  logic [WORD_W-1:0] timing_i,
   output logic              busy_o,
   output logic              cand_o,
   output logic              accept_o,
   output logic              pulse_o,
   output logic              inject_o
);
   localparam int unsigned OFS_ACC = CAND_W;
   localparam int unsigned OFS_PUL = CAND_W + ACC_W;
   localparam int unsigned OFS_INJ = CAND_W + ACC_W + PUL_W;
   localparam int unsigned FW      = max_u(PUL_W, INJ_W);

   generate
      if (CAND_W < 1 || ACC_W < 1 || PUL_W < 1 || INJ_W < 1) begin : g_bad_width
         $error("cal_seq_top: every delay field needs at least one bit");
      end
      if (DIV_STEP < 2) begin : g_bad_div
         $error("cal_seq_top: coarse step must span at least two fast cycles");
      end
   endgenerate

   logic [WORD_W-1:0] cfg_q;
   logic              run_q;
   logic              load;
   logic              ph_first;
   logic              ph_last;
   logic              coarse_fin;
   logic [FW-1:0]     fdly [NFINE];
   logic [NFINE-1:0]  fstrobe;
   logic [NFINE-1:0]  ffired;
   logic              all_fin;

   assign load = start_i && !run_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)     cfg_q <= '0;
      else if (load) cfg_q <= timing_i;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)                  run_q <= 1'b0;
      else if (load)              run_q <= 1'b1;
      else if (run_q && all_fin)  run_q <= 1'b0;
   end

   cal_seq_phase #(.DIV_STEP(DIV_STEP)) u_phase (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .first_o (ph_first),
      .last_o  (ph_last)
   );

   cal_seq_coarse #(.LW(CAND_W), .AW(ACC_W)) u_coarse (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .load_i     (load),
      .run_i      (run_q),
      .ph_first_i (ph_first),
      .ph_last_i  (ph_last),
      .cand_dly_i (cfg_q[0 +: CAND_W]),
      .acc_dly_i  (cfg_q[OFS_ACC +: ACC_W]),
      .cand_o     (cand_o),
      .accept_o   (accept_o),
      .fin_o      (coarse_fin)
   );

   assign fdly[FINE_PULSE]  = FW'(cfg_q[OFS_PUL +: PUL_W]);
   assign fdly[FINE_INJECT] = FW'(cfg_q[OFS_INJ +: INJ_W]);

   generate
      for (genvar g = 0; g < NFINE; g++) begin : g_fine
         cal_seq_fine #(.DW(FW)) u_fine (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .load_i   (load),
            .run_i    (run_q),
            .dly_i    (fdly[g]),
            .strobe_o (fstrobe[g]),
            .fired_o  (ffired[g])
         );
      end
   endgenerate

   assign all_fin  = coarse_fin && (&ffired);
   assign busy_o   = run_q;
   assign pulse_o  = fstrobe[FINE_PULSE];
   assign inject_o = fstrobe[FINE_INJECT];

   // R7 / R8: captured word is untouched while a sequence runs
   p_word_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (busy_o && start_i) |=> $stable(cfg_q));
   // R9: the cycle after reset is idle
   p_reset_idle_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(rst_i) |-> (!busy_o && !cand_o && !accept_o));

endmodule

// File: tb/cal_seq_top_tb_top.sv
module cal_seq_top_tb_top;

   logic        clk = 1'b0;
   logic        rst;
   logic        start;
   logic [18:0] word;
   logic        busy, cand, accept, pulse, inject;

   always #4 clk = ~clk;

   cal_seq_top dut_i (
      .clk_i    (clk),
      .rst_i    (rst),
      .start_i  (start),
      .timing_i (word),
      .busy_o   (busy),
      .cand_o   (cand),
      .accept_o (accept),
      .pulse_o  (pulse),
      .inject_o (inject)
   );

   int    errors = 0;
   int    checks = 0;
   string ctx = "R9";

   // behavioural reference model
   int cyc = 0, t0 = 0, b0 = 0, lastc = 0;
   int eC = 0, eA = 0, eP = 0, eJ = 0;
   bit active = 0;
   bit armed  = 0;
   int ticks  = 0;

   function automatic logic [18:0] mk(input int c, input int a, input int p, input int j);
      // R1 field placement
      return {5'(j), 5'(p), 5'(a), 4'(c)};
   endfunction

   always @(posedge clk) begin
      armed = 1;
      ticks = ticks + 1;
      if (rst) begin
         cyc = 0;
         active = 0;
      end else begin
         if (start && !active) begin
            t0 = cyc;
            eC = int'(word[3:0]);
            eA = int'(word[8:4]);
            eP = int'(word[13:9]);
            eJ = int'(word[18:14]);
            b0 = (t0 / 4 + 1) * 4;
            lastc = b0 + 4 * (eC + eA) + 3;
            if (t0 + 1 + eP > lastc) lastc = t0 + 1 + eP;
            if (t0 + 1 + eJ > lastc) lastc = t0 + 1 + eJ;
            active = 1;
         end
         cyc = cyc + 1;
         if (active && cyc > lastc) active = 0;
      end
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s (ctx %s) cyc=%0d actual=%b expected=%b", tag, ctx, cyc, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (armed) begin
         chk("R6 busy",      busy,   active);
         chk("R2 candidate", cand,   active && cyc >= b0 + 4*eC && cyc <= b0 + 4*eC + 3);
         chk("R3 accept",    accept, active && cyc >= b0 + 4*(eC+eA) && cyc <= b0 + 4*(eC+eA) + 3);
         chk("R4 pulse",     pulse,  active && cyc == t0 + 1 + eP);
         chk("R5 inject",    inject, active && cyc == t0 + 1 + eJ);
      end
   end

   task automatic wait_idle();
      @(negedge clk);
      while (active) @(negedge clk);
   endtask

   task automatic fire(input logic [18:0] w, input int gap);
      @(negedge clk);
      start = 1'b1;
      word  = w;
      @(negedge clk);
      start = 1'b0;
      word  = '0;
      wait_idle();
      repeat (gap) @(negedge clk);
   endtask

   initial begin
      rst = 1'b1; start = 1'b0; word = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      ctx = "R9";                     // reset state
      repeat (3) @(negedge clk);

      ctx = "R1";                     // field decoding, varied values
      fire(mk(3, 2, 7, 1), 0);
      fire(mk(0, 0, 0, 0), 1);        // R3 coincident pair
      fire(mk(15, 31, 31, 31), 2);    // maximum fields
      fire(mk(1, 0, 20, 4), 3);
      fire(mk(5, 1, 0, 0), 0);

      ctx = "R10";                    // starts at every coarse phase
      for (int ph = 0; ph < 4; ph++) fire(mk(2, 3, 9, 17), ph);

      ctx = "R7";                     // start held while busy with another word
      @(negedge clk);
      start = 1'b1; word = mk(2, 3, 4, 5);
      repeat (6) begin
         @(negedge clk);
         word = mk(9, 9, 9, 9);
      end
      start = 1'b0;
      wait_idle();

      ctx = "R8";                     // word rewritten mid-sequence
      @(negedge clk);
      start = 1'b1; word = mk(4, 2, 12, 3);
      @(negedge clk);
      start = 1'b0;
      repeat (8) begin
         @(negedge clk);
         word = word + 19'd12345;
      end
      wait_idle();

      ctx = "R6";                     // back-to-back: start held across idle edge
      @(negedge clk);
      start = 1'b1; word = mk(1, 1, 2, 3);
      wait_idle();
      @(negedge clk);
      word = mk(0, 2, 6, 0);
      wait_idle();
      start = 1'b0;
      word = '0;
      repeat (2) @(negedge clk);

      ctx = "R9";                     // reset mid-sequence
      @(negedge clk);
      start = 1'b1; word = mk(6, 6, 25, 30);
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      repeat (4) @(negedge clk);
      fire(mk(0, 1, 3, 2), 2);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      wait (ticks > 100000);
      errors++;
      checks++;
      $display("FAIL watchdog expired cyc=%0d", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule